// File: doc/BRIEF.md
# 8-bit Arithmetic Logic Unit with Status Flags

This block is the arithmetic stage of a small RISC core. It takes one operation per request. The inputs are an operand byte, a second operand that is either a register byte or an immediate byte, an operation code, and the current carry and zero status bits. One clock edge later it returns a result byte, a write-enable for that byte, six status bits and a mask. The mask shows which status bits the operation updates. The caller merges the masked bits into its own status register and leaves the other bits as they were.

The same stage also handles 16-bit register pairs. It adds or subtracts a 6-bit unsigned immediate to or from a pair, and this takes two cycles. The low byte comes out on the first edge and the high byte on the second edge. The 16-bit flags come with the high byte. While the high byte is being formed, the stage reports busy and ignores new requests.

Top module: `alu8_core`

## Requirements
- R1: While rst_ni is low, busy_o, done_o, res_we_o, res_hi_o, flags_o and flag_mask_o are all 0.
- R2: Opcodes add (0), add-with-carry (1), subtract (2) and subtract-with-carry (3) complete on the edge that accepts them with done_o=1 and res_we_o=1. They use imm_i instead of b_i when use_imm_i=1, and the carry forms take carry_i as the incoming carry or borrow. The mask covers C, Z, N, V, S and H. H is the carry or borrow out of bit 3, C is the carry out of bit 7 (for subtraction, the borrow), and V is two's-complement overflow.
- R3: Compare (4) and compare-with-carry (5) produce the same flags as subtract and subtract-with-carry, with res_we_o=0.
- R4: For subtract-with-carry and compare-with-carry, Z is 1 only when the result byte is zero and zero_i is 1.
- R5: AND (6), OR (7) and XOR (8) report a mask of Z, N, V and S only, and V is 0.
- R6: Invert (9) returns 0xFF minus a_i, with C=1 and V=0, and a mask of C, Z, N, V and S.
- R7: Negate (10) returns 0x00 minus a_i with all six flags in the mask. C=1 unless the result is 0, V=1 only for the result 0x80, and H is the borrow out of bit 3.
- R8: Increment (11) and decrement (12) report a mask of Z, N, V and S, leaving C and H out of the mask. V is set when increment produces 0x80 or when decrement produces 0x7F.
- R9: Word add (13) and word subtract (14) apply imm_i[5:0] to the pair {a_hi_i,a_i}. The first edge outputs the low byte with res_we_o=1, res_hi_o=0, done_o=0, busy_o=1, and flags and mask at 0. The second edge outputs the high byte with res_hi_o=1 and done_o=1. The flags cover all 16 bits with a mask of C, Z, N, V and S.
- R10: A request presented while busy_o=1 is ignored: it produces no done_o and no write.
- R11: flags_o and flag_mask_o use the bit positions C=0, Z=1, N=2, V=3, S=4, H=5. S equals N xor V, and any flag outside the mask reads 0.
- R12: An edge where valid_i=0 and busy_o=0 gives done_o=0 and res_we_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 4 | Operation code |
| use_imm_i | input | 1 | Use imm_i as the second operand |
| a_i | input | 8 | First operand, or low byte of the pair |
| a_hi_i | input | 8 | High byte of the pair for word operations |
| b_i | input | 8 | Second register operand |
| imm_i | input | 8 | Immediate operand (word operations use bits 5:0) |
| carry_i | input | 1 | Current carry status |
| zero_i | input | 1 | Current zero status, used by the chained forms |
| busy_o | output | 1 | High byte of a word operation in progress |
| done_o | output | 1 | Flags and mask are final this cycle |
| res_o | output | 8 | Result byte |
| res_we_o | output | 1 | Result byte should be written |
| res_hi_o | output | 1 | Result byte is the high byte of a pair |
| flags_o | output | 6 | Status bits {H,S,V,N,Z,C} |
| flag_mask_o | output | 6 | Status bits updated by this operation |

## Verification
A word operation's high-byte cycle and a newly arriving request can occur in the same cycle. The bench provokes this by raising valid_i again with an increment request right after a word request has been accepted. It then confirms that the high byte and the 16-bit flags match the model, and that the following edge shows neither done_o nor a write. The chained zero rule is driven directly: identical bytes are compared with zero_i at both levels.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_ADDC = 4'd1,  OP_SUB  = 4'd2,  OP_SUBC = 4'd3,
    OP_CMP  = 4'd4,  OP_CMPC = 4'd5,  OP_AND  = 4'd6,  OP_OR   = 4'd7,
    OP_XOR  = 4'd8,  OP_INV  = 4'd9,  OP_NEG  = 4'd10, OP_INC  = 4'd11,
    OP_DEC  = 4'd12, OP_WADD = 4'd13, OP_WSUB = 4'd14, OP_NONE = 4'd15
  } alu_op_e;

  localparam int F_C = 0;
  localparam int F_Z = 1;
  localparam int F_N = 2;
  localparam int F_V = 3;
  localparam int F_S = 4;
  localparam int F_H = 5;
  localparam int NFLAG = 6;

  localparam logic [NFLAG-1:0] M_ARITH = 6'b111111;
  localparam logic [NFLAG-1:0] M_LOGIC = 6'b011110;
  localparam logic [NFLAG-1:0] M_INV   = 6'b011111;
  localparam logic [NFLAG-1:0] M_STEP  = 6'b011110;
  localparam logic [NFLAG-1:0] M_WORD  = 6'b011111;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W   = 8,
  parameter int NIB = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         half_o,
  output logic         ovf_o
);
  logic [W-1:0] b_eff;
  logic         c_eff;
  logic [W:0]   full;
  logic [NIB:0] nib;

  // subtraction as a + ~b + ~borrow; carries are inverted back to borrows
  assign b_eff  = sub_i ? ~b_i : b_i;
  assign c_eff  = cin_i ^ sub_i;
  assign full   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
  assign nib    = {1'b0, a_i[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, c_eff};
  assign sum_o  = full[W-1:0];
  assign cout_o = full[W] ^ sub_i;
  assign half_o = nib[NIB] ^ sub_i;
  assign ovf_o  = (a_i[W-1] == b_eff[W-1]) && (full[W-1] != a_i[W-1]);
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_INV:  res_o = ~a_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W     = 8,
  parameter int IMM_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [3:0]       op_i,
  input  logic             use_imm_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     a_hi_i,
  input  logic [W-1:0]     b_i,
  input  logic [W-1:0]     imm_i,
  input  logic             carry_i,
  input  logic             zero_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [W-1:0]     res_o,
  output logic             res_we_o,
  output logic             res_hi_o,
  output logic [NFLAG-1:0] flags_o,
  output logic [NFLAG-1:0] flag_mask_o
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ZERO = '0;

  alu_op_e      op;
  logic [W-1:0] b_sel;
  logic [W-1:0] as_a, as_b, as_sum, lg_res;
  logic         as_cin, as_sub, as_c, as_h, as_v;

  logic         busy_q, wsub_q, c_q, zlo_q;
  logic [W-1:0] hi_q;

  logic [W-1:0]     n_res;
  logic             n_we, n_done, n_logic, n_word;
  logic [NFLAG-1:0] n_mask;
  logic             f_c, f_z, f_n, f_v, f_h;
  logic [NFLAG-1:0] n_flags;

  assign op    = alu_op_e'(op_i);
  assign b_sel = use_imm_i ? imm_i : b_i;

  // operand steering for the shared adder
  always_comb begin
    as_a   = a_i;
    as_b   = b_sel;
    as_cin = 1'b0;
    as_sub = 1'b0;
    if (busy_q) begin
      as_a   = hi_q;
      as_b   = ZERO;
      as_cin = c_q;
      as_sub = wsub_q;
    end else begin
      unique case (op)
        OP_ADDC: as_cin = carry_i;
        OP_SUB, OP_CMP: as_sub = 1'b1;
        OP_SUBC, OP_CMPC: begin
          as_sub = 1'b1;
          as_cin = carry_i;
        end
        OP_NEG: begin
          as_a   = ZERO;
          as_b   = a_i;
          as_sub = 1'b1;
        end
        OP_INC: as_b = ONE;
        OP_DEC: begin
          as_b   = ONE;
          as_sub = 1'b1;
        end
        OP_WADD, OP_WSUB: begin
          as_b   = {{(W-IMM_W){1'b0}}, imm_i[IMM_W-1:0]};
          as_sub = (op == OP_WSUB);
        end
        default: ;
      endcase
    end
  end

  alu8_addsub #(.W(W), .NIB(4)) u_addsub (
    .a_i   (as_a),
    .b_i   (as_b),
    .cin_i (as_cin),
    .sub_i (as_sub),
    .sum_o (as_sum),
    .cout_o(as_c),
    .half_o(as_h),
    .ovf_o (as_v)
  );

  alu8_logic #(.W(W)) u_logic (
    .op_i (op),
    .a_i  (a_i),
    .b_i  (b_sel),
    .res_o(lg_res)
  );

  // per-operation result, write and flag selection
  always_comb begin
    n_logic = 1'b0;
    n_word  = 1'b0;
    n_we    = 1'b1;
    n_done  = 1'b1;
    n_mask  = M_ARITH;
    f_c     = as_c;
    f_h     = as_h;
    f_v     = as_v;
    if (busy_q) begin
      n_mask = M_WORD;
    end else begin
      unique case (op)
        OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_NEG: ;
        OP_CMP, OP_CMPC: n_we = 1'b0;
        OP_AND, OP_OR, OP_XOR: begin
          n_logic = 1'b1;
          n_mask  = M_LOGIC;
          f_v     = 1'b0;
        end
        OP_INV: begin
          n_logic = 1'b1;
          n_mask  = M_INV;
          f_v     = 1'b0;
          f_c     = 1'b1;
        end
        OP_INC, OP_DEC: n_mask = M_STEP;
        OP_WADD, OP_WSUB: begin
          n_word = 1'b1;
          n_done = 1'b0;
          n_mask = '0;
        end
        default: begin
          n_we   = 1'b0;
          n_mask = '0;
        end
      endcase
    end
    n_res = n_logic ? lg_res : as_sum;
    f_n   = n_res[W-1];
    f_z   = (n_res == ZERO);
    if (busy_q)
      f_z = f_z & zlo_q;
    else if (op == OP_SUBC || op == OP_CMPC)
      f_z = f_z & zero_i;
    n_flags        = '0;
    n_flags[F_C]   = f_c;
    n_flags[F_Z]   = f_z;
    n_flags[F_N]   = f_n;
    n_flags[F_V]   = f_v;
    n_flags[F_S]   = f_n ^ f_v;
    n_flags[F_H]   = f_h;
    n_flags        = n_flags & n_mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      wsub_q      <= 1'b0;
      c_q         <= 1'b0;
      zlo_q       <= 1'b0;
      hi_q        <= '0;
      done_o      <= 1'b0;
      res_o       <= '0;
      res_we_o    <= 1'b0;
      res_hi_o    <= 1'b0;
      flags_o     <= '0;
      flag_mask_o <= '0;
    end else if (busy_q) begin
      busy_q      <= 1'b0;
      done_o      <= 1'b1;
      res_o       <= n_res;
      res_we_o    <= 1'b1;
      res_hi_o    <= 1'b1;
      flags_o     <= n_flags;
      flag_mask_o <= n_mask;
    end else if (valid_i) begin
      busy_q      <= n_word;
      if (n_word) begin
        wsub_q <= (op == OP_WSUB);
        c_q    <= as_c;
        zlo_q  <= (as_sum == ZERO);
        hi_q   <= a_hi_i;
      end
      done_o      <= n_done;
      res_o       <= n_res;
      res_we_o    <= n_we;
      res_hi_o    <= 1'b0;
      flags_o     <= n_flags;
      flag_mask_o <= n_mask;
    end else begin
      done_o      <= 1'b0;
      res_we_o    <= 1'b0;
      res_hi_o    <= 1'b0;
      flags_o     <= '0;
      flag_mask_o <= '0;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [3:0]       op_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             res_we_o,
  input logic             res_hi_o,
  input logic [NFLAG-1:0] flags_o,
  input logic [NFLAG-1:0] flag_mask_o
);
  logic take;
  assign take = valid_i && !busy_o;

  p_cmp_no_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && (op_i == OP_CMP || op_i == OP_CMPC) |=> done_o && !res_we_o);

  p_logic_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR)
    |=> flag_mask_o == M_LOGIC && !flags_o[F_V]);

  p_inv_carry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && op_i == OP_INV |=> flags_o[F_C] && !flags_o[F_V]);

  p_step_keeps_c_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && (op_i == OP_INC || op_i == OP_DEC)
    |=> !flag_mask_o[F_C] && !flag_mask_o[F_H]);

  p_word_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && (op_i == OP_WADD || op_i == OP_WSUB)
    |=> busy_o && res_we_o && !res_hi_o && !done_o);

  p_busy_ends_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o && done_o && res_hi_o);

  p_unmasked_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (flags_o & ~flag_mask_o) == '0);

  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i && !busy_o |=> !done_o && !res_we_o);
endmodule

bind alu8_core alu8_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .op_i       (op_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .res_we_o   (res_we_o),
  .res_hi_o   (res_hi_o),
  .flags_o    (flags_o),
  .flag_mask_o(flag_mask_o)
);

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [3:0] op_i = '0;
  logic       use_imm_i = 1'b0;
  logic [7:0] a_i = '0, a_hi_i = '0, b_i = '0, imm_i = '0;
  logic       carry_i = 1'b0, zero_i = 1'b0;
  logic       busy_o, done_o, res_we_o, res_hi_o;
  logic [7:0] res_o;
  logic [5:0] flags_o, flag_mask_o;

  int n_checks = 0;
  int n_errs = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  alu8_core dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .use_imm_i(use_imm_i), .a_i(a_i), .a_hi_i(a_hi_i), .b_i(b_i),
    .imm_i(imm_i), .carry_i(carry_i), .zero_i(zero_i), .busy_o(busy_o),
    .done_o(done_o), .res_o(res_o), .res_we_o(res_we_o),
    .res_hi_o(res_hi_o), .flags_o(flags_o), .flag_mask_o(flag_mask_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int sx8(input logic [7:0] v);
    return v[7] ? int'(v) - 256 : int'(v);
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1, 4'd2, 4'd3: return "R2";
      4'd4, 4'd5:             return "R3";
      4'd6, 4'd7, 4'd8:       return "R5";
      4'd9:                   return "R6";
      4'd10:                  return "R7";
      4'd11, 4'd12:           return "R8";
      default:                return "R9";
    endcase
  endfunction

  // reference model from the requirements; flags {H,S,V,N,Z,C}
  task automatic model(input logic [3:0] op, input logic [7:0] a, ahi, b, imm,
                       input logic ui, c, z,
                       output logic [15:0] r, output logic we,
                       output logic [5:0] fl, output logic [5:0] mk);
    logic [7:0] bb;
    int ci, full, sfull, p, k;
    logic fc, fz, fn, fv, fh;
    bb = ui ? imm : b;
    ci = (op == 4'd1 || op == 4'd3 || op == 4'd5) ? int'(c) : 0;
    we = 1'b1; mk = 6'b111111; fc = 0; fh = 0; fv = 0; r = '0;
    case (op)
      4'd0, 4'd1: begin
        full = int'(a) + int'(bb) + ci;
        r = 16'(full & 255); fc = full > 255;
        fh = (int'(a[3:0]) + int'(bb[3:0]) + ci) > 15;
        sfull = sx8(a) + sx8(bb) + ci; fv = sfull > 127 || sfull < -128;
      end
      4'd2, 4'd3, 4'd4, 4'd5, 4'd10: begin
        logic [7:0] x, y;
        x = (op == 4'd10) ? 8'h00 : a;
        y = (op == 4'd10) ? a : bb;
        full = int'(x) - int'(y) - ci;
        r = 16'(full & 255); fc = full < 0;
        fh = (int'(x[3:0]) - int'(y[3:0]) - ci) < 0;
        sfull = sx8(x) - sx8(y) - ci; fv = sfull > 127 || sfull < -128;
        if (op == 4'd4 || op == 4'd5) we = 1'b0;
      end
      4'd6: begin r = {8'h0, a & bb}; mk = 6'b011110; end
      4'd7: begin r = {8'h0, a | bb}; mk = 6'b011110; end
      4'd8: begin r = {8'h0, a ^ bb}; mk = 6'b011110; end
      4'd9: begin r = {8'h0, 8'hFF - a}; fc = 1; mk = 6'b011111; end
      4'd11: begin r = {8'h0, a + 8'd1}; fv = (a == 8'h7F); mk = 6'b011110; end
      4'd12: begin r = {8'h0, a - 8'd1}; fv = (a == 8'h80); mk = 6'b011110; end
      default: begin
        p = int'({ahi, a}); k = int'(imm[5:0]);
        full = (op == 4'd13) ? p + k : p - k;
        r = 16'(full & 65535);
        fc = full > 65535 || full < 0;
        sfull = (p > 32767 ? p - 65536 : p) + ((op == 4'd13) ? k : -k);
        fv = sfull > 32767 || sfull < -32768;
        mk = 6'b011111;
      end
    endcase
    if (op >= 4'd13) begin
      fn = r[15]; fz = (r == 16'h0);
    end else begin
      fn = r[7]; fz = (r[7:0] == 8'h0);
      if (op == 4'd3 || op == 4'd5) fz = fz & z;
    end
    fl = {fh, fn ^ fv, fv, fn, fz, fc} & mk;
  endtask

  task automatic run_op(input string tag_in, input logic [3:0] op,
                        input logic [7:0] a, ahi, b, imm,
                        input logic ui, c, z, input bit collide);
    logic [15:0] r; logic we; logic [5:0] fl, mk;
    string tag;
    tag = (tag_in == "") ? tag_of(op) : tag_in;
    model(op, a, ahi, b, imm, ui, c, z, r, we, fl, mk);
    @(negedge clk_i);
    op_i = op; a_i = a; a_hi_i = ahi; b_i = b; imm_i = imm;
    use_imm_i = ui; carry_i = c; zero_i = z; valid_i = 1'b1;
    @(negedge clk_i);
    if (op >= 4'd13) begin
      if (collide) begin
        op_i = 4'd11; a_i = 8'h7F; valid_i = 1'b1;
      end else valid_i = 1'b0;
      chk(tag, "low byte", {8'h0, res_o}, {8'h0, r[7:0]});
      chk(tag, "low we/hi/busy/done", {12'h0, res_we_o, res_hi_o, busy_o, done_o}, 16'b1010);
      chk(tag, "low flags/mask", {4'h0, flags_o, flag_mask_o}, 16'h0);
      @(negedge clk_i);
      valid_i = 1'b0;
      chk(tag, "high byte", {8'h0, res_o}, {8'h0, r[15:8]});
      chk(tag, "high we/hi/busy/done", {12'h0, res_we_o, res_hi_o, busy_o, done_o}, 16'b1101);
      chk(tag, "word flags", {10'h0, flags_o}, {10'h0, fl});
      chk(tag, "word mask", {10'h0, flag_mask_o}, {10'h0, mk});
      if (collide) begin
        @(negedge clk_i);
        chk("R10", "ignored request done/we", {14'h0, done_o, res_we_o}, 16'h0);
      end
    end else begin
      valid_i = 1'b0;
      chk(tag, "done", {15'h0, done_o}, 16'h1);
      chk(tag, "we", {15'h0, res_we_o}, {15'h0, we});
      if (we) chk(tag, "result", {8'h0, res_o}, {8'h0, r[7:0]});
      chk(tag, "flags", {10'h0, flags_o}, {10'h0, fl});
      chk(tag, "mask", {10'h0, flag_mask_o}, {10'h0, mk});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_checks++; n_errs++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    #(CLK_PERIOD * 2);
    // R1: outputs idle while reset is held
    chk("R1", "reset outputs",
        {2'b0, busy_o, done_o, res_we_o, res_hi_o, flags_o, flag_mask_o[5:2]}, 16'h0);
    chk("R1", "reset mask low", {14'h0, flag_mask_o[1:0]}, 16'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i); @(negedge clk_i);
    chk("R12", "idle done/we", {14'h0, done_o, res_we_o}, 16'h0);

    // R2 corners: half carry, overflow, carry with zero, immediate, borrows
    run_op("R2", 4'd0, 8'h0F, 0, 8'h01, 0, 0, 0, 0, 0);
    run_op("R2", 4'd0, 8'h7F, 0, 8'h01, 0, 0, 0, 0, 0);
    run_op("R2", 4'd1, 8'hFF, 0, 8'h00, 0, 0, 1, 0, 0);
    run_op("R2", 4'd0, 8'h10, 0, 8'h00, 8'h35, 1, 0, 0, 0);
    run_op("R2", 4'd2, 8'h10, 0, 8'h01, 0, 0, 0, 0, 0);
    run_op("R2", 4'd3, 8'h00, 0, 8'h00, 0, 0, 1, 1, 0);
    // R3 compare leaves result unwritten
    run_op("R3", 4'd4, 8'h80, 0, 8'h01, 0, 0, 0, 0, 0);
    // R4 chained zero
    run_op("R4", 4'd5, 8'h33, 0, 8'h33, 0, 0, 0, 1, 0);
    run_op("R4", 4'd5, 8'h33, 0, 8'h33, 0, 0, 0, 0, 0);
    run_op("R4", 4'd3, 8'h34, 0, 8'h33, 0, 0, 0, 1, 0);
    run_op("R4", 4'd3, 8'h34, 0, 8'h33, 0, 0, 1, 1, 0);
    // R5/R6/R7/R8
    run_op("R5", 4'd6, 8'hF0, 0, 8'h00, 8'h80, 1, 1, 0, 0);
    run_op("R5", 4'd8, 8'hAA, 0, 8'h55, 0, 0, 0, 0, 0);
    run_op("R6", 4'd9, 8'hFF, 0, 0, 0, 0, 0, 0, 0);
    run_op("R7", 4'd10, 8'h80, 0, 0, 0, 0, 0, 0, 0);
    run_op("R7", 4'd10, 8'h00, 0, 0, 0, 0, 1, 0, 0);
    run_op("R7", 4'd10, 8'h01, 0, 0, 0, 0, 0, 0, 0);
    run_op("R8", 4'd11, 8'h7F, 0, 0, 0, 0, 1, 0, 0);
    run_op("R8", 4'd12, 8'h80, 0, 0, 0, 0, 0, 0, 0);
    run_op("R8", 4'd12, 8'h00, 0, 0, 0, 0, 1, 0, 0);
    // R9 word corners, R10 collision
    run_op("R9", 4'd13, 8'hFF, 8'h00, 0, 8'h01, 0, 0, 0, 0);
    run_op("R9", 4'd13, 8'hFF, 8'hFF, 0, 8'h01, 0, 0, 0, 0);
    run_op("R9", 4'd14, 8'h00, 8'h00, 0, 8'h01, 0, 0, 0, 0);
    run_op("R9", 4'd14, 8'h00, 8'h80, 0, 8'h3F, 0, 0, 0, 0);
    run_op("R10", 4'd13, 8'hC0, 8'h7F, 0, 8'h3F, 0, 0, 0, 1);
    run_op("R10", 4'd14, 8'h05, 8'h12, 0, 8'h07, 0, 0, 0, 1);

    // R11 flag layout and masking are checked on every random result
    for (int i = 0; i < 600; i++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 14));
      run_op("", op, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
             1'($urandom), 1'($urandom), 1'($urandom), ($urandom_range(0, 3) == 0));
    end

    @(negedge clk_i); @(negedge clk_i);
    chk("R12", "idle after traffic", {14'h0, done_o, res_we_o}, 16'h0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule